// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

The block is a watchdog timer reached through a small register interface with 32-bit data. A down-counter advances on a slow reference tick that arrives as a one-cycle enable, already synchronous to the bus clock. Software writes a reload value, turns on counting and the reset output, and then refreshes the counter at intervals. If the count runs out, the block raises an interrupt and starts a new period. If the interrupt is still pending when the second period also runs out, the block asserts a system reset. The effective timeout is therefore two programmed periods. For example, with a 32768 Hz tick, a reload value of 32768 × 128 gives 128 s per period and 256 s to reset.

A lock register protects the load, control and interrupt-clear registers against stray writes. Writing a single 32-bit key opens them, and writing any other value closes them again. A refresh is normally done as unlock, write the load register, then lock. Reads are allowed at all times.

Top module: `wdt_top`

## Requirements
- R1: After reset the lock register reads 0 (unlocked), control reads 0, load (offset 0x000) and value (offset 0x004) read 0xFFFFFFFF, and wdog_irq and wdog_rst are 0.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks and the lock register then reads 0. A write of any other value there locks and it then reads 1. The lock register accepts writes whether locked or not.
- R3: While locked, writes to offsets 0x000, 0x008 and 0x00C change nothing: load, value, control, wdog_irq and wdog_rst keep their values.
- R4: An unlocked write to offset 0x000 sets both the load register and the live count to the written value, visible from the next cycle. Offset 0x004 reads the live count.
- R5: At control offset 0x008, bit 0 enables counting and the interrupt, and bit 1 enables the reset output. Only bits [1:0] read back; the other bits read 0. The count drops by one per tick only while bit 0 is 1.
- R6: A tick with bit 0 set, arriving while the count is 1 or 0, is an expiry. The count reloads from the load register and the interrupt becomes pending, so a period lasts load ticks. wdog_irq equals the pending interrupt gated by bit 0.
- R7: An expiry while the interrupt is already pending and bit 1 is set asserts wdog_rst from the next cycle. wdog_rst then stays at 1 until the block is reset. With bit 1 clear, no reset is asserted.
- R8: An unlocked write to offset 0x00C clears the pending interrupt and reloads the count from the load register.
- R9: An unlocked write to offset 0x000 or 0x00C takes effect in a cycle that also carries a tick, and that tick is discarded. No expiry, no decrement and no reset results from it.
- R10: Reads of offset 0x00C and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_tick | input | 1 | One-cycle enable from the slow reference |
| bus_write | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdog_irq | output | 1 | Interrupt output, level |
| wdog_rst | output | 1 | System reset request, sticky |

## Verification
A software refresh can land in the same clock cycle as the tick that would expire the count. This applies to a load write or an interrupt clear. The bench provokes it by stepping the count to 1 and then issuing the write together with a tick in one cycle. With the interrupt already pending, that same setup would otherwise be the fatal second expiry. The cycle is judged correct if the count holds the written or reloaded value, the interrupt state follows the write alone, and wdog_rst stays at 0.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BUS_ADDR_W = 12;
    localparam int BUS_DATA_W = 32;

    localparam logic [BUS_ADDR_W-1:0] OFS_LOAD  = 12'h000;
    localparam logic [BUS_ADDR_W-1:0] OFS_VALUE = 12'h004;
    localparam logic [BUS_ADDR_W-1:0] OFS_CTRL  = 12'h008;
    localparam logic [BUS_ADDR_W-1:0] OFS_ICLR  = 12'h00C;
    localparam logic [BUS_ADDR_W-1:0] OFS_LOCK  = 12'hC00;

    localparam logic [BUS_DATA_W-1:0] OPEN_KEY = 32'h1ACCE551;

    typedef struct packed {
        logic rst_en;
        logic int_en;
    } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] load_val,
    output ctrl_t             ctrl,
    output logic              locked,
    output logic              load_wr,
    output logic              iclr_wr
);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(OFS_ICLR);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFS_LOCK);
    localparam logic [DATA_W-1:0] KEY     = DATA_W'(OPEN_KEY);

    typedef struct packed {
        logic              locked;
        logic [DATA_W-1:0] load;
        ctrl_t             ctrl;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d   = reg_q;
        load_wr = 1'b0;
        iclr_wr = 1'b0;
        if (bus_write) begin
            if (bus_addr == A_LOCK) begin
                reg_d.locked = (bus_wdata != KEY);
            end else if (!reg_q.locked) begin
                case (bus_addr)
                    A_LOAD: begin
                        reg_d.load = bus_wdata;
                        load_wr    = 1'b1;
                    end
                    A_CTRL: begin
                        reg_d.ctrl.int_en = bus_wdata[0];
                        reg_d.ctrl.rst_en = bus_wdata[1];
                    end
                    A_ICLR:  iclr_wr = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.locked <= 1'b0;
            reg_q.load   <= '1;
            reg_q.ctrl   <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_LOAD:  bus_rdata = reg_q.load;
            A_VALUE: bus_rdata = count_val;
            A_CTRL:  bus_rdata = DATA_W'({reg_q.ctrl.rst_en, reg_q.ctrl.int_en});
            A_LOCK:  bus_rdata = DATA_W'(reg_q.locked);
            default: bus_rdata = '0;
        endcase
    end

    assign load_val = reg_q.load;
    assign ctrl     = reg_q.ctrl;
    assign locked   = reg_q.locked;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = BUS_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             iclr_wr,
    input  logic [CNT_W-1:0] new_load,
    input  logic [CNT_W-1:0] load_val,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] count_val,
    output logic             irq_pend,
    output logic             rst_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             pend;
        logic             rst;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (load_wr) begin
            core_d.count = new_load;
        end else if (iclr_wr) begin
            core_d.count = load_val;
            core_d.pend  = 1'b0;
        end else if (tick && ctrl.int_en) begin
            if (core_q.count <= ONE) begin
                core_d.count = load_val;
                core_d.pend  = 1'b1;
                if (core_q.pend && ctrl.rst_en) begin
                    core_d.rst = 1'b1;
                end
            end else begin
                core_d.count = core_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.count <= '1;
            core_q.pend  <= 1'b0;
            core_q.rst   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign count_val = core_q.count;
    assign irq_pend  = core_q.pend;
    assign rst_out   = core_q.rst;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_tick,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_irq,
    output logic              wdog_rst
);
    logic [DATA_W-1:0] count_val;
    logic [DATA_W-1:0] load_val;
    ctrl_t             ctrl;
    logic              locked;
    logic              load_wr;
    logic              iclr_wr;
    logic              irq_pend;

    wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_val (count_val),
        .bus_rdata (bus_rdata),
        .load_val  (load_val),
        .ctrl      (ctrl),
        .locked    (locked),
        .load_wr   (load_wr),
        .iclr_wr   (iclr_wr)
    );

    wdt_core #(.CNT_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (count_tick),
        .load_wr   (load_wr),
        .iclr_wr   (iclr_wr),
        .new_load  (bus_wdata),
        .load_val  (load_val),
        .ctrl      (ctrl),
        .count_val (count_val),
        .irq_pend  (irq_pend),
        .rst_out   (wdog_rst)
    );

    assign wdog_irq = irq_pend & ctrl.int_en;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              count_tick,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] count_val,
    input logic [DATA_W-1:0] load_val,
    input logic              int_en,
    input logic              rst_en,
    input logic              locked,
    input logic              load_wr,
    input logic              iclr_wr,
    input logic              irq_pend,
    input logic              wdog_rst
);
    // R2: the key always opens the lock
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_addr == ADDR_W'(OFS_LOCK) && bus_wdata == DATA_W'(OPEN_KEY)) |=> !locked);

    // R3: locked load writes leave the load register alone
    p_locked_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_write && bus_addr == ADDR_W'(OFS_LOAD)) |=> $stable(load_val));

    // R5: no counting while disabled and no bus write
    p_hold_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && !bus_write) |=> $stable(count_val));

    // R6: expiry makes the interrupt pending
    p_expiry_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && int_en && !load_wr && !iclr_wr && count_val <= DATA_W'(1)) |=> irq_pend);

    // R7: reset only after a pending interrupt with reset enabled, then sticky
    p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> ($past(irq_pend) && $past(rst_en)));
    p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> wdog_rst);

    // R9: a write in the same cycle as a tick leaves reset untouched
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && (load_wr || iclr_wr) && !wdog_rst) |=> !wdog_rst);
endmodule

bind wdt_top wdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_tick (count_tick),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count_val  (count_val),
    .load_val   (load_val),
    .int_en     (ctrl.int_en),
    .rst_en     (ctrl.rst_en),
    .locked     (locked),
    .load_wr    (load_wr),
    .iclr_wr    (iclr_wr),
    .irq_pend   (irq_pend),
    .wdog_rst   (wdog_rst)
);

// File: tb/wdt_top_test.sv
`timescale 1ns/1ps
module wdt_top_test;
    localparam logic [11:0] O_LOAD = 12'h000, O_VAL = 12'h004, O_CTRL = 12'h008,
                            O_ICLR = 12'h00C, O_LOCK = 12'hC00;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_tick = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_irq;
    logic        wdog_rst;

    int checks = 0;
    int errors = 0;

    wdt_top uut (
        .clk(clk), .rst_n(rst_n), .count_tick(count_tick), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic tk);
        bus_write = wr; bus_addr = a; bus_wdata = d; count_tick = tk;
        @(negedge clk);
        bus_write = 1'b0; count_tick = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, O_VAL, '0, 1'b1);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        do_reset();
        rd(O_LOCK, v); check("R1 lock", v, 0);
        rd(O_CTRL, v); check("R1 ctrl", v, 0);
        rd(O_LOAD, v); check("R1 load", v, 32'hFFFFFFFF);
        rd(O_VAL, v);  check("R1 value", v, 32'hFFFFFFFF);
        check("R1 irq", wdog_irq, 0);
        check("R1 rst", wdog_rst, 0);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        do_reset();
        wr(O_LOCK, 32'h0);
        rd(O_LOCK, v); check("R2 locked by zero", v, 1);
        wr(O_LOAD, 32'd5);
        rd(O_LOAD, v); check("R3 load ignored", v, 32'hFFFFFFFF);
        rd(O_VAL, v);  check("R3 value ignored", v, 32'hFFFFFFFF);
        wr(O_CTRL, 32'h3);
        rd(O_CTRL, v); check("R3 ctrl ignored", v, 0);
        wr(O_LOCK, KEY ^ 32'h1);
        rd(O_LOCK, v); check("R2 near key locks", v, 1);
        wr(O_LOCK, KEY);
        rd(O_LOCK, v); check("R2 key unlocks", v, 0);
        wr(O_LOCK, 32'h1234);
        rd(O_LOCK, v); check("R2 relock", v, 1);
    endtask

    task automatic t_load_count;
        logic [31:0] v;
        do_reset();
        wr(O_LOAD, 32'd10);
        rd(O_LOAD, v); check("R4 load", v, 10);
        rd(O_VAL, v);  check("R4 value", v, 10);
        ticks(2);
        rd(O_VAL, v);  check("R5 no count when disabled", v, 10);
        wr(O_CTRL, 32'hFFFF_FFFD);
        rd(O_CTRL, v); check("R5 ctrl readback", v, 1);
        ticks(3);
        rd(O_VAL, v);  check("R5 count down", v, 7);
        wr(O_CTRL, 32'h0);
        ticks(2);
        rd(O_VAL, v);  check("R5 stopped", v, 7);
    endtask

    task automatic t_two_stage;
        logic [31:0] v;
        do_reset();
        wr(O_LOAD, 32'd3);
        wr(O_CTRL, 32'h3);
        ticks(2);
        check("R6 no early irq", wdog_irq, 0);
        ticks(1);
        check("R6 irq at expiry", wdog_irq, 1);
        rd(O_VAL, v); check("R6 reload", v, 3);
        check("R7 no rst first", wdog_rst, 0);
        ticks(2);
        check("R7 no rst early", wdog_rst, 0);
        ticks(1);
        check("R7 rst second", wdog_rst, 1);
        wr(O_CTRL, 32'h0);
        wr(O_ICLR, 32'h0);
        ticks(4);
        check("R7 rst sticky", wdog_rst, 1);
        do_reset();
        check("R7 rst cleared by reset", wdog_rst, 0);
        wr(O_LOAD, 32'd2);
        wr(O_CTRL, 32'h1);
        ticks(4);
        check("R7 no rst when disabled", wdog_rst, 0);
        check("R6 irq pending", wdog_irq, 1);
        wr(O_CTRL, 32'h0);
        check("R6 irq masked", wdog_irq, 0);
        wr(O_CTRL, 32'h1);
        check("R6 irq unmasked", wdog_irq, 1);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        do_reset();
        wr(O_LOAD, 32'd4);
        wr(O_CTRL, 32'h3);
        ticks(5);
        check("R6 pending before clear", wdog_irq, 1);
        wr(O_ICLR, 32'h0);
        check("R8 irq cleared", wdog_irq, 0);
        rd(O_VAL, v); check("R8 count reloaded", v, 4);
        rd(O_ICLR, v); check("R10 iclr reads zero", v, 0);
        rd(12'h010, v); check("R10 unmapped zero", v, 0);
        ticks(4);
        wr(O_LOCK, 32'h0);
        wr(O_ICLR, 32'h0);
        check("R3 locked clear ignored", wdog_irq, 1);
        rd(O_VAL, v); check("R3 locked clear no reload", v, 4);
        ticks(3);
        wr(O_LOAD, 32'd9);
        rd(O_VAL, v); check("R3 locked load no restart", v, 1);
        ticks(1);
        check("R7 rst after locked refresh", wdog_rst, 1);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        do_reset();
        wr(O_LOAD, 32'd2);
        wr(O_CTRL, 32'h3);
        ticks(1);
        cyc(1'b1, O_LOAD, 32'd5, 1'b1);
        rd(O_VAL, v); check("R9 load beats tick", v, 5);
        check("R9 no irq from lost tick", wdog_irq, 0);
        ticks(5);
        check("R6 pending", wdog_irq, 1);
        ticks(4);
        rd(O_VAL, v); check("R6 count at one", v, 1);
        cyc(1'b1, O_ICLR, 32'h0, 1'b1);
        check("R9 clear beats tick irq", wdog_irq, 0);
        check("R9 clear beats tick rst", wdog_rst, 0);
        rd(O_VAL, v); check("R9 clear reload", v, 5);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_lock();
        t_load_count();
        t_two_stage();
        t_clear();
        t_same_cycle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule